// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Front End

This block sits between five interrupt request pins and a small 8-bit processor core. It decides which request is serviced next. It presents that decision as a valid flag, a 16-bit restart address and a flag for the one source that has no built-in address. The five sources are handled differently:

- **Non-maskable source.** It must see a clean rising edge and then stay high. After it has been serviced it is locked out until its line falls and rises again.
- **Edge-latched source.** Its rising edge is captured into a pending latch, so the line may drop before the request is serviced.
- **Two level-sensitive sources.** Each must be held high until it is serviced.
- **External source.** It is level-sensitive and carries no address of its own; the bus agent supplies one.

The core drives the controller through single-cycle strobes:

- a global enable set strobe and a global enable clear strobe;
- a mask-write strobe carrying a data byte, which updates the three per-source masks and can discard a latched edge;
- an acknowledge strobe, which takes the current winner and clears the global enable.

A status byte reports the masks, the global enable, the three pending conditions and the level of a serial-data-in pin. All pins pass through a synchronizer before they are used.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Fixed priority, highest first: non-maskable (nmi), edge-latched (edge), level A (lvl_a), level B (lvl_b), external (ext). Only the highest eligible source is reported.
- R2: The vector is 0x0024 for nmi, 0x003C for edge, 0x0034 for lvl_a and 0x002C for lvl_b. When ext wins, `irq_nonvec_o` is 1 and the vector is 0x0000. In every other case `irq_nonvec_o` is 0.
- R3: nmi ignores the global enable and all masks. It is reported one cycle after a synchronized rising edge, and only while its synchronized line stays high. A request line that is high for a single clock is never reported.
- R4: Acknowledging nmi removes it from the next cycle on, even if its line stays high. It returns only after the line goes low and then high again.
- R5: A rising edge on the edge source sets a pending latch. The request stays valid after the line falls, and acknowledging the edge source clears the latch.
- R6: lvl_a and lvl_b are level-sensitive and need both the global enable and their own mask bit at 0. ext needs only the global enable. Request pins reach the outputs two clocks after they change, because of a two-flop synchronizer.
- R7: On a mask write, data bits 0, 1 and 2 become the masks of lvl_b, lvl_a and edge (1 = masked), but only if data bit 3 is 1. Otherwise the masks keep their old values. Data bits 5 to 7 have no effect.
- R8: A mask write with data bit 4 = 1 clears the edge pending latch. If a new rising edge is detected in the same cycle, the latch stays set.
- R9: The status byte is laid out as:
  - bits 2:0: masks of edge, lvl_a, lvl_b (bit 2 down to bit 0);
  - bit 3: global enable;
  - bit 4: lvl_b line;
  - bit 5: lvl_a line;
  - bit 6: edge latch;
  - bit 7: synchronized serial-data-in pin.
- R10: After reset the global enable is 0, all three masks are 1, the pending latch and the nmi edge state are clear, and the status byte reads 0x07 while all pins are low.
- R11: An acknowledge taken while `irq_valid_o` is 1 clears the global enable. This clear wins over a set strobe in the same cycle. The clear strobe also wins over the set strobe. An acknowledge while `irq_valid_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_req_i | input | 1 | Non-maskable request pin |
| edge_req_i | input | 1 | Edge-latched request pin |
| lvl_a_req_i | input | 1 | Level-sensitive request A (higher) |
| lvl_b_req_i | input | 1 | Level-sensitive request B (lower) |
| ext_req_i | input | 1 | External non-vectored request pin |
| sdi_i | input | 1 | Serial data in pin, shown in status |
| ien_set_i | input | 1 | Global enable set strobe |
| ien_clr_i | input | 1 | Global enable clear strobe |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_data_i | input | 8 | Mask write data byte |
| ack_i | input | 1 | Acknowledge strobe |
| irq_valid_o | output | 1 | A serviceable request exists |
| irq_vector_o | output | 16 | Restart address of the winner |
| irq_nonvec_o | output | 1 | Winner is the external source |
| status_o | output | 8 | Mask, enable and pending status byte |

## Verification
Two pairs of functions can land in the same cycle:

- **Edge latch: set versus clear.** The bench raises the edge pin and counts the two synchronizer edges. It then issues a mask write with the clear bit so that the write is sampled on the same clock as the detected rising edge. Status bit 6 must still read 1; a second clear on its own must then drop it.
- **Global enable: acknowledge versus set.** The bench pulses the acknowledge strobe and the set strobe together while a request is valid. Status bit 3 must read 0 afterwards.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned VEC_W = 16;
  // source index = priority rank, highest index wins
  localparam int unsigned IDX_EXT  = 0;
  localparam int unsigned IDX_LVLB = 1;
  localparam int unsigned IDX_LVLA = 2;
  localparam int unsigned IDX_EDGE = 3;
  localparam int unsigned IDX_NMI  = 4;

  // restart address = 4 * (2n+1); nmi sits at 9 half-steps
  function automatic logic [VEC_W-1:0] src_vector(input int unsigned idx);
    int unsigned half;
    if (idx == IDX_EXT) return '0;
    half = (idx == IDX_NMI) ? 9 : 9 + 2 * idx;
    return VEC_W'(4 * half);
  endfunction
endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_s_i,
  input  logic edge_s_i,
  input  logic ack_nmi_i,
  input  logic ack_edge_i,
  input  logic clr_edge_i,
  output logic nmi_req_o,
  output logic edge_pend_o
);
  logic nmi_prev_q, edge_prev_q, nmi_armed_q, edge_pend_q;
  logic nmi_rise, edge_rise;

  assign nmi_rise  = nmi_s_i & ~nmi_prev_q;
  assign edge_rise = edge_s_i & ~edge_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_prev_q  <= 1'b0;
      edge_prev_q <= 1'b0;
      nmi_armed_q <= 1'b0;
      edge_pend_q <= 1'b0;
    end else begin
      nmi_prev_q  <= nmi_s_i;
      edge_prev_q <= edge_s_i;
      // lockout: ack disarms, only a fresh rise re-arms
      if (ack_nmi_i)     nmi_armed_q <= 1'b0;
      else if (nmi_rise) nmi_armed_q <= 1'b1;
      else if (!nmi_s_i) nmi_armed_q <= 1'b0;
      // a new edge beats any clear in the same cycle
      if (edge_rise)                    edge_pend_q <= 1'b1;
      else if (ack_edge_i | clr_edge_i) edge_pend_q <= 1'b0;
    end
  end

  assign nmi_req_o   = nmi_armed_q & nmi_s_i;
  assign edge_pend_o = edge_pend_q;

  // R4
  nmi_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_nmi_i |=> !nmi_req_o);
  // R8
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_rise |=> edge_pend_o);
  // R5
  edge_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_edge_i && !edge_rise) |=> !edge_pend_o);
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic             valid_o,
  output logic [VEC_W-1:0] vector_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    vector_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) vector_o = vector_o | src_vector(i);
  end

  assign valid_o = |grant_o;

  // R1
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_req_i,
  input  logic             edge_req_i,
  input  logic             lvl_a_req_i,
  input  logic             lvl_b_req_i,
  input  logic             ext_req_i,
  input  logic             sdi_i,
  input  logic             ien_set_i,
  input  logic             ien_clr_i,
  input  logic             mask_wr_i,
  input  logic [7:0]       mask_data_i,
  input  logic             ack_i,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vector_o,
  output logic             irq_nonvec_o,
  output logic [7:0]       status_o
);
  localparam int unsigned PINS = NSRC + 1;

  logic [PINS-1:0] pins_s;
  logic            s_nmi, s_edge, s_lva, s_lvb, s_ext, s_sdi;
  logic            ie_q;
  logic [2:0]      mask_q;
  logic            nmi_req, edge_pend, accept;
  logic [NSRC-1:0] req, grant;
  logic            unused_bits;

  assign unused_bits = ^mask_data_i[7:5];

  prio_irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, nmi_req_i, edge_req_i, lvl_a_req_i, lvl_b_req_i, ext_req_i}),
    .q_o   (pins_s)
  );
  assign {s_sdi, s_nmi, s_edge, s_lva, s_lvb, s_ext} = pins_s;

  assign accept = ack_i & irq_valid_o;

  prio_irq_pend u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nmi_s_i    (s_nmi),
    .edge_s_i   (s_edge),
    .ack_nmi_i  (accept & grant[IDX_NMI]),
    .ack_edge_i (accept & grant[IDX_EDGE]),
    .clr_edge_i (mask_wr_i & mask_data_i[4]),
    .nmi_req_o  (nmi_req),
    .edge_pend_o(edge_pend)
  );

  assign req[IDX_NMI]  = nmi_req;
  assign req[IDX_EDGE] = ie_q & ~mask_q[2] & edge_pend;
  assign req[IDX_LVLA] = ie_q & ~mask_q[1] & s_lva;
  assign req[IDX_LVLB] = ie_q & ~mask_q[0] & s_lvb;
  assign req[IDX_EXT]  = ie_q & s_ext;

  prio_irq_arb #(.N(NSRC)) u_arb (
    .req_i   (req),
    .grant_o (grant),
    .valid_o (irq_valid_o),
    .vector_o(irq_vector_o)
  );

  assign irq_nonvec_o = grant[IDX_EXT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      mask_q <= 3'b111;
    end else begin
      if (accept | ien_clr_i) ie_q <= 1'b0;
      else if (ien_set_i)     ie_q <= 1'b1;
      if (mask_wr_i && mask_data_i[3]) mask_q <= mask_data_i[2:0];
    end
  end

  assign status_o = {s_sdi, edge_pend, s_lva, s_lvb, ie_q, mask_q};

  // R11
  accept_clears_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !status_o[3]);
  // R7
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && !mask_data_i[3]) |=> $stable(status_o[2:0]));
  // R3
  only_nmi_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && !status_o[3]) |-> irq_vector_o == 16'h0024);
  // R2
  nonvec_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_nonvec_o |-> (irq_valid_o && irq_vector_o == '0));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 0, edg = 0, lva = 0, lvb = 0, ext = 0, sdi = 0;
  logic ien_set = 0, ien_clr = 0, mwr = 0, ack = 0;
  logic [7:0] mdata = '0;
  logic valid, nonvec;
  logic [15:0] vec;
  logic [7:0] stat;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .nmi_req_i(nmi), .edge_req_i(edg),
    .lvl_a_req_i(lva), .lvl_b_req_i(lvb), .ext_req_i(ext), .sdi_i(sdi),
    .ien_set_i(ien_set), .ien_clr_i(ien_clr), .mask_wr_i(mwr),
    .mask_data_i(mdata), .ack_i(ack), .irq_valid_o(valid),
    .irq_vector_o(vec), .irq_nonvec_o(nonvec), .status_o(stat)
  );

  // {ie, mask[2:0], lva, lvb, ext, exp_valid, exp_nonvec, exp_vec}
  localparam logic [24:0] TBL [9] = '{
    {1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b1, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000},
    {1'b1, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h002C},
    {1'b1, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0034},
    {1'b1, 3'b010, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h002C},
    {1'b1, 3'b011, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000},
    {1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 3'b111, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_set();   ien_set = 1; tick(1); ien_set = 0; endtask
  task automatic pulse_clr();   ien_clr = 1; tick(1); ien_clr = 0; endtask
  task automatic pulse_ack();   ack = 1;     tick(1); ack = 0;     endtask
  task automatic mask_write(input logic [7:0] d);
    mdata = d; mwr = 1; tick(1); mwr = 0; mdata = '0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10
    chk("R10 status", 32'(stat), 32'h07);
    chk("R10 valid", 32'(valid), 32'h0);

    // R6 / R1 / R2 / R9: table walk
    for (int k = 0; k < 9; k++) begin
      logic [24:0] e;
      e = TBL[k];
      if (e[24]) pulse_set(); else pulse_clr();
      mask_write({4'b0000, 1'b1, e[23:21]});
      lva = e[20]; lvb = e[19]; ext = e[18];
      tick(3);
      chk("R6 valid", 32'(valid), 32'(e[17]));
      chk("R2 nonvec", 32'(nonvec), 32'(e[16]));
      chk("R1 vector", 32'(vec), 32'(e[15:0]));
      chk("R9 status", 32'(stat[5:0]), 32'({e[20], e[19], e[24], e[23:21]}));
      lva = 0; lvb = 0; ext = 0;
      tick(3);
    end

    // R3: single-clock nmi pulse never reported
    pulse_clr();
    nmi = 1; tick(1); nmi = 0;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 6; k++) begin tick(1); seen += int'(valid); end
      chk("R3 glitch ignored", 32'(seen), 32'h0);
    end
    // R3: held nmi reported with enable off
    nmi = 1; tick(3);
    chk("R3 nmi valid", 32'(valid), 32'h1);
    chk("R3 nmi vector", 32'(vec), 32'h0024);
    // R4: lockout after acknowledge
    pulse_ack();
    chk("R4 locked", 32'(valid), 32'h0);
    tick(3);
    chk("R4 still locked", 32'(valid), 32'h0);
    nmi = 0; tick(3); nmi = 1; tick(3);
    chk("R4 rearmed", 32'(valid), 32'h1);
    pulse_ack(); nmi = 0; tick(3);

    // R5: latched edge survives the line falling
    pulse_set(); mask_write(8'h08);
    edg = 1; tick(1); edg = 0; tick(4);
    chk("R5 valid", 32'(valid), 32'h1);
    chk("R5 vector", 32'(vec), 32'h003C);
    chk("R5 pending", 32'(stat[6]), 32'h1);
    pulse_ack();
    chk("R5 cleared", 32'(stat[6]), 32'h0);
    chk("R11 ie cleared", 32'(stat[3]), 32'h0);

    // R1: edge over lvl_a, then lvl_a after re-enable
    pulse_set(); lva = 1; edg = 1; tick(1); edg = 0; tick(4);
    chk("R1 edge first", 32'(vec), 32'h003C);
    pulse_ack(); pulse_set(); tick(1);
    chk("R1 lvl_a next", 32'(vec), 32'h0034);
    lva = 0; pulse_clr(); tick(3);

    // R7: no update without bit 3, bit 5 ignored
    mask_write(8'h07);
    chk("R7 masks kept", 32'(stat[2:0]), 32'h0);
    mask_write(8'h2D);
    chk("R7 bit5 ignored", 32'(stat[2:0]), 32'h5);
    mask_write(8'h08);

    // R8: clear bit drops latch, masks untouched
    edg = 1; tick(1); edg = 0; tick(4);
    chk("R8 latched", 32'(stat[6]), 32'h1);
    mask_write(8'h10);
    chk("R8 cleared", 32'(stat[6]), 32'h0);
    chk("R8 masks kept", 32'(stat[2:0]), 32'h0);
    // R8: clear and fresh edge in the same cycle
    edg = 1; tick(2);
    mdata = 8'h10; mwr = 1; tick(1); mwr = 0; mdata = '0;
    chk("R8 edge wins", 32'(stat[6]), 32'h1);
    mask_write(8'h10);
    chk("R8 cleared again", 32'(stat[6]), 32'h0);
    edg = 0; tick(3);

    // R11: accept beats set, clr beats set, stray ack ignored
    pulse_set(); ext = 1; tick(3);
    ack = 1; ien_set = 1; tick(1); ack = 0; ien_set = 0;
    chk("R11 accept wins", 32'(stat[3]), 32'h0);
    ext = 0; tick(3);
    ien_set = 1; ien_clr = 1; tick(1); ien_set = 0; ien_clr = 0;
    chk("R11 clr wins", 32'(stat[3]), 32'h0);
    pulse_set(); pulse_ack();
    chk("R11 stray ack", 32'(stat[3]), 32'h1);

    // R9: serial data bit
    sdi = 1; tick(3);
    chk("R9 sdi", 32'(stat[7]), 32'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule